// File: doc/BRIEF.md
# UART Modem Control and Local Loopback

This block is the per-channel modem-signal logic of a UART. It lives between the host register bus, the serial pins and the channel's transmit and receive paths. It holds a small set of host-writable control registers and drives the active-low request-to-send pin. The pin is driven either from a software bit or, with automatic flow control on, from the receive FIFO fill level compared against a programmable trigger. It also samples the active-low ring-indicator pin through a synchroniser. The ring state is kept in a modem status register together with a sticky trailing-edge flag, and an interrupt request is raised from that flag when software enables it.

The block also switches the channel into local loopback. In that mode the transmit pin is parked at the idle high level and the receive pin is ignored. The transmit bit stream from the core is fed straight back to the receive path, and the ring status follows a control bit instead of the pin. The host bus is a plain strobe bus: a write takes effect on the rising edge of the active-low write strobe, and a read of the status register clears the sticky flag on the rising edge of the read strobe.

The serial lines carry single bits, not words. No valid/ready handshake is used anywhere and there is no back-pressure: every pin is a plain level.

Top module: `uart_modem_ctl`

## Requirements
- R1: A register is written with `wdata` at address `addr` only on a rising edge of `wr_n`, detected on `clk`. Holding `wr_n` low writes nothing. Addresses: 1 = interrupt enable, 2 = feature, 4 = modem control, 5 = flow trigger. Each of them reads back on `rdata` when `addr` selects it.
- R2: While `rst` is high, `rts_n`, `txd_pin` and `rx_core` are 1. After reset, `irq` is 0 and every register reads 0.
- R3: With automatic flow control off, `rts_n` is the inverse of modem control bit 1, one cycle after the register changes.
- R4: With feature bit 6 set, `rts_n` is 1 when `rx_level` is at or above the flow trigger register and 0 below it, one cycle after the level changes.
- R5: Status register (address 6) bit 6 reads 1 while the synchronised `ri_n` is low. Outside loopback it follows the pin after two clock edges.
- R6: A low-to-high change of the synchronised ring input sets status bit 2. A high-to-low change does not set it.
- R7: Status bit 2 stays set until a rising edge of `rd_n` with `addr` = 6. That read returns the flag before clearing it. A new trailing edge in the same cycle keeps the flag set.
- R8: `irq` is 1 exactly when status bit 2 is set and interrupt-enable bit 3 is set.
- R9: With modem control bit 4 set (loopback), `txd_pin` is 1, `rx_core` equals `tx_core`, and `rxd_pin` and `ri_n` have no effect.
- R10: In loopback, status bit 6 equals modem control bit 3. Clearing that bit sets status bit 2.
- R11: Outside loopback and reset, `txd_pin` equals `tx_core` and `rx_core` equals `rxd_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset |
| wr_n | input | 1 | Active-low write strobe; write on rising edge |
| rd_n | input | 1 | Active-low read strobe; status read clears flag on rising edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| tx_core | input | 1 | Serial bit from the transmit serialiser |
| txd_pin | output | 1 | Transmit pin |
| rxd_pin | input | 1 | Receive pin |
| rx_core | output | 1 | Serial bit to the receive serialiser |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rts_n | output | 1 | Request to send, active low |
| ri_n | input | 1 | Ring indicator, active low |
| irq | output | 1 | Modem status interrupt request |

## Verification
The bench holds the write strobe low for several cycles to confirm that nothing commits before the rising edge. A design that wrote on the level would show the new value early. It steps the receive level across the flow trigger from below, exactly at, and above it; an off-by-one comparator flips `rts_n` one level late. Both edges of the ring input are driven, checking that only the trailing edge sets the flag and that the flag survives until an explicit status read. A level-following flag or an edge detector of the wrong polarity would drop or invert the interrupt. In loopback the bench toggles the receive and ring pins and expects no effect on `rx_core` or status. A design that leaked the pin through would show it there.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADR_INTEN = 3'd1;
  localparam logic [REG_AW-1:0] ADR_FEAT  = 3'd2;
  localparam logic [REG_AW-1:0] ADR_MCTL  = 3'd4;
  localparam logic [REG_AW-1:0] ADR_RTRIG = 3'd5;
  localparam logic [REG_AW-1:0] ADR_MSTAT = 3'd6;

  localparam int BIT_MSI_EN   = 3;
  localparam int BIT_AUTO_RTS = 6;
  localparam int BIT_RTS_REQ  = 1;
  localparam int BIT_LOOP_RI  = 3;
  localparam int BIT_LOOPBACK = 4;
  localparam int BIT_ST_TERI  = 2;
  localparam int BIT_ST_RING  = 6;

  typedef struct packed {
    logic [REG_DW-1:0] inten;
    logic [REG_DW-1:0] feat;
    logic [REG_DW-1:0] mctl;
    logic [REG_DW-1:0] rtrig;
  } ctl_regs_t;
endpackage

// File: rtl/modem_host_regs.sv
module modem_host_regs
  import uart_modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output ctl_regs_t         regs,
  output logic              stat_rd
);
  logic wr_q, rd_q, wr_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_edge = wr_n && !wr_q;
  assign stat_rd = rd_n && !rd_q && (addr == ADR_MSTAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_edge) begin
      unique case (addr)
        ADR_INTEN: regs.inten <= wdata;
        ADR_FEAT:  regs.feat  <= wdata;
        ADR_MCTL:  regs.mctl  <= wdata;
        ADR_RTRIG: regs.rtrig <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/modem_ri_detect.sv
module modem_ri_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ri_n,
  input  logic loop_en,
  input  logic loop_ri,
  input  logic clr,
  output logic ring,
  output logic teri_flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic ring_prev, trail;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b1;
        else if (s == 0) sync_q[s] <= ri_n;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign ring  = loop_en ? loop_ri : !sync_q[SYNC_STAGES-1];
  assign trail = ring_prev && !ring;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_prev <= 1'b0;
      teri_flag <= 1'b0;
    end else begin
      ring_prev <= ring;
      if (trail) teri_flag <= 1'b1;
      else if (clr) teri_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/modem_rts_ctrl.sv
module modem_rts_ctrl #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  logic             sw_req,
  input  logic [LVL_W-1:0] level,
  input  logic [7:0]       trig,
  output logic             rts_n
);
  localparam int CMP_W = (LVL_W > 8) ? LVL_W : 8;
  logic [CMP_W-1:0] lvl_x, trig_x;
  logic             at_trig;

  assign lvl_x   = CMP_W'(level);
  assign trig_x  = CMP_W'(trig);
  assign at_trig = lvl_x >= trig_x;

  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b1;
    else if (auto_en) rts_n <= at_trig;
    else rts_n <= !sw_req;
  end
endmodule

// File: rtl/modem_loop_route.sv
module modem_loop_route (
  input  logic rst,
  input  logic loop_en,
  input  logic tx_core,
  input  logic rxd_pin,
  output logic txd_pin,
  output logic rx_core
);
  always_comb begin
    if (rst) begin
      txd_pin = 1'b1;
      rx_core = 1'b1;
    end else if (loop_en) begin
      txd_pin = 1'b1;
      rx_core = tx_core;
    end else begin
      txd_pin = tx_core;
      rx_core = rxd_pin;
    end
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int LVL_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             tx_core,
  output logic             txd_pin,
  input  logic             rxd_pin,
  output logic             rx_core,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rts_n,
  input  logic             ri_n,
  output logic             irq
);
  ctl_regs_t regs;
  logic stat_rd, ring, teri_flag, loop_en, auto_en, msi_en;
  logic [REG_DW-1:0] mstat;

  assign loop_en = regs.mctl[BIT_LOOPBACK];
  assign auto_en = regs.feat[BIT_AUTO_RTS];
  assign msi_en  = regs.inten[BIT_MSI_EN];

  modem_host_regs u_regs (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
    .wdata(wdata), .regs(regs), .stat_rd(stat_rd)
  );

  modem_ri_detect #(.SYNC_STAGES(SYNC_STAGES)) u_ri (
    .clk(clk), .rst(rst), .ri_n(ri_n), .loop_en(loop_en),
    .loop_ri(regs.mctl[BIT_LOOP_RI]), .clr(stat_rd),
    .ring(ring), .teri_flag(teri_flag)
  );

  modem_rts_ctrl #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst(rst), .auto_en(auto_en),
    .sw_req(regs.mctl[BIT_RTS_REQ]), .level(rx_level),
    .trig(regs.rtrig), .rts_n(rts_n)
  );

  modem_loop_route u_route (
    .rst(rst), .loop_en(loop_en), .tx_core(tx_core), .rxd_pin(rxd_pin),
    .txd_pin(txd_pin), .rx_core(rx_core)
  );

  always_comb begin
    mstat = '0;
    mstat[BIT_ST_RING] = ring;
    mstat[BIT_ST_TERI] = teri_flag;
  end

  always_comb begin
    unique case (addr)
      ADR_INTEN: rdata = regs.inten;
      ADR_FEAT:  rdata = regs.feat;
      ADR_MCTL:  rdata = regs.mctl;
      ADR_RTRIG: rdata = regs.rtrig;
      ADR_MSTAT: rdata = mstat;
      default:   rdata = '0;
    endcase
  end

  assign irq = teri_flag && msi_en;
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             rts_n,
  input logic             txd_pin,
  input logic             rx_core,
  input logic             tx_core,
  input logic             rxd_pin,
  input logic             irq,
  input logic             loop_en,
  input logic             auto_en,
  input logic             msi_en,
  input logic             sw_req,
  input logic [7:0]       trig,
  input logic [LVL_W-1:0] rx_level,
  input logic             ring,
  input logic             teri_flag,
  input logic             stat_rd
);
  // R2: outputs parked while reset is held
  always @(negedge clk) begin
    if (rst) begin
      a_r2_reset_outputs: assert (rts_n && txd_pin && rx_core);
    end
  end

  // R3
  a_r3_manual_rts: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> rts_n == !$past(sw_req));

  // R4
  a_r4_auto_rts: assert property (@(posedge clk) disable iff (rst)
    auto_en |=> rts_n == ($past(32'(rx_level)) >= $past(32'(trig))));

  // R6
  a_r6_trail_sets: assert property (@(posedge clk) disable iff (rst)
    $fell(ring) |=> teri_flag);

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    teri_flag && !stat_rd |=> teri_flag);

  // R8
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq == (teri_flag && msi_en));

  // R9
  a_r9_loop_route: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> txd_pin && (rx_core == tx_core));

  // R11
  a_r11_normal_route: assert property (@(posedge clk) disable iff (rst)
    !loop_en |-> (txd_pin == tx_core) && (rx_core == rxd_pin));
endmodule

bind uart_modem_ctl uart_modem_ctl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .rts_n(rts_n), .txd_pin(txd_pin), .rx_core(rx_core),
  .tx_core(tx_core), .rxd_pin(rxd_pin), .irq(irq), .loop_en(loop_en),
  .auto_en(auto_en), .msi_en(msi_en), .sw_req(regs.mctl[1]),
  .trig(regs.rtrig), .rx_level(rx_level), .ring(ring),
  .teri_flag(teri_flag), .stat_rd(stat_rd)
);

// File: tb/uart_modem_ctl_test.sv
`timescale 1ns/1ps
module uart_modem_ctl_test;
  localparam int LVL_W = 7;

  logic clk = 0, rst = 1, wr_n = 1, rd_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic tx_core = 1, txd_pin, rxd_pin = 1, rx_core, rts_n, ri_n = 1, irq;
  logic [LVL_W-1:0] rx_level = 0;

  always #2.5 clk = ~clk;

  uart_modem_ctl #(.LVL_W(LVL_W)) uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_core(tx_core), .txd_pin(txd_pin),
    .rxd_pin(rxd_pin), .rx_core(rx_core), .rx_level(rx_level),
    .rts_n(rts_n), .ri_n(ri_n), .irq(irq)
  );

  typedef struct {
    string      req;
    int         sel;   // 0 rts_n, 1 txd_pin, 2 rx_core, 3 irq, 4 rdata
    logic [7:0] exp;
  } item_t;

  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = sb.pop_front();
      case (it.sel)
        0: got = {7'd0, rts_n};
        1: got = {7'd0, txd_pin};
        2: got = {7'd0, rx_core};
        3: got = {7'd0, irq};
        default: got = rdata;
      endcase
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
      end
    end
  end

  task automatic expect_item(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
    wait (sb.size() == 0);
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_n = 0;
    tick(1);
    wr_n = 1;
    tick(1);
  endtask

  task automatic rd_stat();
    addr = 3'd6; rd_n = 0;
    tick(1);
    rd_n = 1;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tx_core = 0; rxd_pin = 0;
    tick(3);
    expect_item("R2 rts_n in reset", 0, 8'd1);
    expect_item("R2 txd_pin in reset", 1, 8'd1);
    expect_item("R2 rx_core in reset", 2, 8'd1);
    rst = 0;
    tick(2);
    expect_item("R2 irq after reset", 3, 8'd0);
    addr = 3'd4; expect_item("R2 mctl after reset", 4, 8'h00);

    // R11 normal routing
    tx_core = 0; rxd_pin = 1;
    expect_item("R11 txd follows core", 1, 8'd0);
    expect_item("R11 rx_core follows pin", 2, 8'd1);
    tx_core = 1; rxd_pin = 0;
    expect_item("R11 txd follows core hi", 1, 8'd1);
    expect_item("R11 rx_core follows pin lo", 2, 8'd0);

    // R3 manual RTS, R1 readback
    wr(3'd4, 8'h02);
    expect_item("R3 rts low on request", 0, 8'd0);
    addr = 3'd4; expect_item("R1 mctl readback", 4, 8'h02);
    wr(3'd4, 8'h00);
    expect_item("R3 rts high when cleared", 0, 8'd1);

    // R1 held strobe writes nothing until it rises
    addr = 3'd5; wdata = 8'h2A; wr_n = 0;
    tick(3);
    expect_item("R1 no write while strobe low", 4, 8'h00);
    wr_n = 1;
    tick(1);
    addr = 3'd5; expect_item("R1 write on rising strobe", 4, 8'h2A);

    // R4 automatic flow control
    wr(3'd5, 8'd16);
    wr(3'd2, 8'h40);
    wr(3'd4, 8'h02);
    rx_level = 7'd15; expect_item("R4 below trigger", 0, 8'd0);
    rx_level = 7'd16; expect_item("R4 at trigger", 0, 8'd1);
    rx_level = 7'd40; expect_item("R4 above trigger", 0, 8'd1);
    rx_level = 7'd15; expect_item("R4 falls below", 0, 8'd0);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h00);

    // R5-R8 ring indicator
    wr(3'd1, 8'h08);
    ri_n = 0; tick(4);
    addr = 3'd6; expect_item("R5 ring seen, R6 no flag on leading edge", 4, 8'h40);
    expect_item("R8 no irq on leading edge", 3, 8'd0);
    ri_n = 1; tick(4);
    expect_item("R6 trailing edge flag", 4, 8'h04);
    expect_item("R8 irq raised", 3, 8'd1);
    tick(10);
    expect_item("R7 flag held", 4, 8'h04);
    addr = 3'd6; rd_n = 0; tick(1);
    expect_item("R7 read returns flag", 4, 8'h04);
    rd_n = 1; tick(1);
    expect_item("R7 cleared by read", 4, 8'h00);
    expect_item("R8 irq drops", 3, 8'd0);

    wr(3'd1, 8'h00);
    ri_n = 0; tick(4); ri_n = 1; tick(4);
    addr = 3'd6; expect_item("R8 flag set while disabled", 4, 8'h04);
    expect_item("R8 irq masked", 3, 8'd0);
    rd_stat();
    wr(3'd1, 8'h08);

    // R9, R10 loopback
    wr(3'd4, 8'h10);
    tx_core = 0; rxd_pin = 1;
    expect_item("R9 txd parked high", 1, 8'd1);
    expect_item("R9 rx_core from tx_core", 2, 8'd0);
    tx_core = 1; rxd_pin = 0;
    expect_item("R9 rx pin ignored", 2, 8'd1);
    ri_n = 0; tick(4); ri_n = 1; tick(4);
    addr = 3'd6; expect_item("R9 ri pin ignored", 4, 8'h00);
    expect_item("R9 no irq from pin", 3, 8'd0);
    wr(3'd4, 8'h18);
    addr = 3'd6; expect_item("R10 ring from control bit", 4, 8'h40);
    wr(3'd4, 8'h10);
    tick(1);
    addr = 3'd6; expect_item("R10 trailing edge from control bit", 4, 8'h04);
    expect_item("R10 irq in loopback", 3, 8'd1);
    rd_stat();
    wr(3'd4, 8'h00);
    tx_core = 0;
    expect_item("R11 txd restored after loopback", 1, 8'd0);

    // R2 reset mid-run
    wr(3'd4, 8'h02);
    rst = 1; tick(2);
    expect_item("R2 rts parked in reset", 0, 8'd1);
    rst = 0; tick(2);
    addr = 3'd4; expect_item("R2 mctl cleared", 4, 8'h00);
    addr = 3'd1; expect_item("R2 inten cleared", 4, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule